// File: doc/BRIEF.md
# Sub-word Register Access Adapter

This block sits between a master that issues byte, halfword or word accesses and a register file that only accepts whole 32-bit reads and writes. A narrow read fetches the aligned word and returns it shifted down, so the addressed lane lands at bit 0. A narrow write is widened before it reaches the register file. How it is widened depends on a per-offset register class supplied by an external decoder:

- **Plain read/write registers** get a read-modify-write that keeps every untouched bit.
- **Write-one-to-clear and set/clear alias registers** receive only the placed lane, with zeros elsewhere. No read is made first, so no other bit sees a side effect.

Word accesses pass straight through. Writes to read-only or unmapped offsets never reach the register file, and neither do malformed accesses.

The upstream side holds its request until `up_ready` pulses. Most requests finish in the cycle they are presented. Reads and read-modify-writes take two cycles. The downstream port returns read data one cycle after a read is issued.

Top module: `subword_reg_adapter`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `up_ready` and `dn_valid` are both low.
- R2: A byte or halfword read of a class 00 or class 10 offset issues one downstream read at the aligned address in the request cycle. In the next cycle `up_ready` is high and `up_rdata` equals the returned word shifted right by 8 times `up_addr[1:0]`. Size codes are 00 byte, 01 halfword, 10 word.
- R3: A word read returns the whole downstream word unshifted, with `up_ready` in the second cycle. A word write to class 00 or 01 forwards `up_wdata` unchanged as one downstream write, with `up_ready` in the request cycle.
- R4: A byte or halfword write to class 00 (plain read/write) makes exactly two downstream accesses:
  - first a read of the aligned word;
  - then, in the next cycle, a write of `(old & ~(M << 8*off)) | ((wdata & M) << 8*off)`, where M is 0xFF for a byte and 0xFFFF for a halfword. `up_ready` is high in that second cycle.
- R5: A byte or halfword write to class 01 (clear/set alias) makes one downstream write of `(wdata & M) << 8*off`, with every other bit zero and no downstream read. `up_ready` is high in the request cycle.
- R6: A write to class 10 (read-only) or class 11 (unmapped), or a read of class 11, makes no downstream access. It completes in the request cycle, and a read returns 0.
- R7: A halfword access with `up_addr[0]`=1, or any access with size code 11, is dropped: no downstream access, completion in the request cycle, and read data 0.
- R8: Every downstream access uses `up_addr` with its two low bits cleared.
- R9: `up_ready` is high for exactly one cycle per request: in the request cycle for single-access operations, and in the second cycle for reads and read-modify-writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream request present, held until up_ready |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| up_addr | input | ADDR_W | Byte address |
| up_wdata | input | DATA_W | Write data, narrow data in the low bits |
| up_class | input | 2 | Class of the addressed register: 00 RW, 01 zero-fill alias, 10 read-only, 11 unmapped |
| up_ready | output | 1 | Request complete this cycle |
| up_rdata | output | DATA_W | Read data, valid with up_ready on a read |
| dn_valid | output | 1 | Downstream access this cycle |
| dn_we | output | 1 | Downstream write strobe |
| dn_addr | output | ADDR_W | Word-aligned downstream address |
| dn_wdata | output | DATA_W | Downstream write word |
| dn_rdata | input | DATA_W | Downstream read word, one cycle after the read |

## Verification
A wrong sequencer state shows at the ports within one cycle, in one of three ways:
- a read-modify-write whose second access is missing or is a read;
- an `up_ready` in the wrong cycle;
- a drop case that still reaches the register file.

A wrong lane mask or shift amount shows in the very access that uses it:
- on a plain register, as corrupted neighbour bits in the written-back word;
- on an alias register, as stray ones outside the lane.

The bench keeps its own copy of the register file and compares it word for word after every write. It also counts downstream reads per request, so a zero-fill write that reads first is caught even when the data comes out right.

// File: rtl/sw_adapter_pkg.sv
// Shared types for the sub-word register access adapter.
// Assumes the encodings listed in the brief are fixed by the upstream bus.
package sw_adapter_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        RC_RW    = 2'b00,
        RC_ZFILL = 2'b01,
        RC_RO    = 2'b10,
        RC_NONE  = 2'b11
    } reg_class_e;

    typedef enum logic [1:0] {
        ACT_DROP  = 2'b00,
        ACT_READ  = 2'b01,
        ACT_WRITE = 2'b10,
        ACT_RMW   = 2'b11
    } action_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_RD_WAIT = 2'b01,
        ST_MERGE   = 2'b10
    } seq_state_e;
endpackage

// File: rtl/sw_lane_unit.sv
// Lane placement datapath: builds the lane mask for the access size, shifts
// write data up into its lane, merges it with an old word, and shifts read
// data down. Purely combinational. Assumes word accesses ignore the offset.
module sw_lane_unit
    import sw_adapter_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   offset,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  word_in,
    output logic [DATA_W-1:0]  lane_mask_sh,
    output logic [DATA_W-1:0]  wr_placed,
    output logic [DATA_W-1:0]  wr_merged,
    output logic [DATA_W-1:0]  rd_aligned
);
    logic [DATA_W-1:0] lane_mask;
    logic [OFF_W+2:0]  shamt;

    // Lane width mask for the requested size.
    always_comb begin
        case (size)
            SZ_BYTE: lane_mask = DATA_W'(8'hFF);
            SZ_HALF: lane_mask = DATA_W'(16'hFFFF);
            default: lane_mask = '1;
        endcase
    end

    // Bit shift amount: offset in bytes times eight, zero for a word.
    always_comb begin
        shamt = (size == SZ_WORD) ? '0 : {offset, 3'b000};
    end

    // Placement, merge and read alignment.
    always_comb begin
        lane_mask_sh = lane_mask << shamt;
        wr_placed    = (wdata & lane_mask) << shamt;
        wr_merged    = (word_in & ~lane_mask_sh) | wr_placed;
        rd_aligned   = word_in >> shamt;
    end
endmodule

// File: rtl/sw_access_decode.sv
// Access classifier: from direction, size, alignment and register class it
// picks one of drop, plain read, single write or read-modify-write.
// Assumes the class input already reflects the addressed offset.
module sw_access_decode
    import sw_adapter_pkg::*;
(
    input  logic       we,
    input  acc_size_e  size,
    input  logic       addr_lsb,
    input  reg_class_e cls,
    output action_e    action
);
    logic bad_shape;

    // Malformed shape: reserved size or odd halfword.
    always_comb begin
        bad_shape = (size == SZ_RSVD) || (size == SZ_HALF && addr_lsb);
    end

    // Action choice.
    always_comb begin
        if (bad_shape) begin
            action = ACT_DROP;
        end else if (!we) begin
            action = (cls == RC_NONE) ? ACT_DROP : ACT_READ;
        end else begin
            case (cls)
                RC_RW:    action = (size == SZ_WORD) ? ACT_WRITE : ACT_RMW;
                RC_ZFILL: action = ACT_WRITE;
                default:  action = ACT_DROP;
            endcase
        end
    end
endmodule

// File: rtl/sw_sequencer.sv
// Request sequencer: issues zero, one or two downstream accesses per upstream
// request and raises the ready pulse. Assumes the upstream request stays
// stable until ready, and downstream read data arrives one cycle after a read.
module sw_sequencer
    import sw_adapter_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  action_e action,
    output logic    up_ready,
    output logic    dn_valid,
    output logic    dn_we,
    output logic    use_merge,
    output logic    rd_take
);
    seq_state_e state, state_nx;

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and per-cycle strobes.
    always_comb begin
        state_nx  = state;
        up_ready  = 1'b0;
        dn_valid  = 1'b0;
        dn_we     = 1'b0;
        use_merge = 1'b0;
        rd_take   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    case (action)
                        ACT_DROP: up_ready = 1'b1;
                        ACT_WRITE: begin
                            dn_valid = 1'b1;
                            dn_we    = 1'b1;
                            up_ready = 1'b1;
                        end
                        ACT_READ: begin
                            dn_valid = 1'b1;
                            state_nx = ST_RD_WAIT;
                        end
                        default: begin
                            dn_valid = 1'b1;
                            state_nx = ST_MERGE;
                        end
                    endcase
                end
            end
            ST_RD_WAIT: begin
                up_ready = 1'b1;
                rd_take  = 1'b1;
                state_nx = ST_IDLE;
            end
            ST_MERGE: begin
                dn_valid  = 1'b1;
                dn_we     = 1'b1;
                use_merge = 1'b1;
                up_ready  = 1'b1;
                state_nx  = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // A plain read completes with data in the following cycle.
    assert_read_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && action == ACT_READ) |=> (up_ready && rd_take));

    // The read of a read-modify-write is followed by its write.
    assert_rmw_write_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_we && action == ACT_RMW) |=> (dn_valid && dn_we));

    // After a ready pulse the sequencer is free for the next request.
    assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |=> (state == ST_IDLE));

    // A dropped request never reaches the register file.
    assert_drop_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && action == ACT_DROP) |-> !dn_valid);
endmodule

// File: rtl/subword_reg_adapter.sv
// Sub-word register access adapter top. Widens byte and halfword accesses
// into whole-word accesses, by read-modify-write or zero-fill according to
// the register class. Assumes DATA_W is 32 or another power-of-two multiple
// of 8, and that the class input is decoded from up_addr by the caller.
module subword_reg_adapter
    import sw_adapter_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic              up_we,
    input  logic [1:0]        up_size,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [1:0]        up_class,
    output logic              up_ready,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_valid,
    output logic              dn_we,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata
);
    action_e           action;
    logic              use_merge;
    logic              rd_take;
    logic [DATA_W-1:0] lane_mask_sh;
    logic [DATA_W-1:0] wr_placed;
    logic [DATA_W-1:0] wr_merged;
    logic [DATA_W-1:0] rd_aligned;

    sw_access_decode u_decode (
        .we       (up_we),
        .size     (acc_size_e'(up_size)),
        .addr_lsb (up_addr[0]),
        .cls      (reg_class_e'(up_class)),
        .action   (action)
    );

    sw_lane_unit #(.DATA_W(DATA_W)) u_lane (
        .size         (acc_size_e'(up_size)),
        .offset       (up_addr[OFF_W-1:0]),
        .wdata        (up_wdata),
        .word_in      (dn_rdata),
        .lane_mask_sh (lane_mask_sh),
        .wr_placed    (wr_placed),
        .wr_merged    (wr_merged),
        .rd_aligned   (rd_aligned)
    );

    sw_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (up_valid),
        .action    (action),
        .up_ready  (up_ready),
        .dn_valid  (dn_valid),
        .dn_we     (dn_we),
        .use_merge (use_merge),
        .rd_take   (rd_take)
    );

    // Downstream address and data selection, upstream read data.
    always_comb begin
        dn_addr  = {up_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        dn_wdata = use_merge ? wr_merged : wr_placed;
        up_rdata = rd_take ? rd_aligned : '0;
    end

    // The write-back of a merge keeps every bit outside the lane.
    assert_merge_keeps_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_we && use_merge) |-> (((dn_wdata ^ dn_rdata) & ~lane_mask_sh) == '0));

    // A narrow single write carries zeros outside its lane.
    assert_zfill_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_we && !use_merge && up_size != SZ_WORD) |-> ((dn_wdata & ~lane_mask_sh) == '0));

    // Odd halfword accesses never touch the register file.
    assert_misaligned_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_size == SZ_HALF && up_addr[0]) |-> !dn_valid);

    // Writes to read-only or unmapped offsets never touch the register file.
    assert_ro_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_we && up_class[1]) |-> !dn_valid);
endmodule

// File: tb/test_subword_reg_adapter.sv
// Scoreboard bench: the driver pushes the expected outcome of each request,
// the monitor pops it at the ready pulse and compares.
module test_subword_reg_adapter;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef struct {
        string       tag;
        logic        we;
        logic [31:0] rd;
        int          lat;
        int          acc;
        int          rdacc;
        logic [11:0] daddr;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              up_valid = 1'b0;
    logic              up_we = 1'b0;
    logic [1:0]        up_size = 2'b00;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [DATA_W-1:0] up_wdata = '0;
    logic [1:0]        up_class = 2'b00;
    logic              up_ready;
    logic [DATA_W-1:0] up_rdata;
    logic              dn_valid;
    logic              dn_we;
    logic [ADDR_W-1:0] dn_addr;
    logic [DATA_W-1:0] dn_wdata;
    logic [DATA_W-1:0] dn_rdata = '0;

    logic [31:0] mem [16];
    logic [31:0] exp_mem [16];
    item_t q[$];
    int nchk = 0;
    int nfail = 0;
    int lat_c = 0;
    int acc_c = 0;
    int rd_c = 0;

    always #2.5 clk = ~clk;

    subword_reg_adapter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_subword_reg_adapter (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_we(up_we),
        .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_class(up_class), .up_ready(up_ready), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_we(dn_we), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    // Downstream register file model with one-cycle read latency.
    always @(posedge clk) begin
        if (dn_valid) begin
            if (dn_we) mem[dn_addr[5:2]] <= dn_wdata;
            else       dn_rdata <= mem[dn_addr[5:2]];
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: counts cycles and downstream accesses, compares at ready.
    always @(negedge clk) begin
        if (rst_n && up_valid) begin
            lat_c++;
            if (dn_valid) begin
                acc_c++;
                if (!dn_we) rd_c++;
                if (q.size() > 0) check("R8", "dn_addr", 32'(dn_addr), 32'(q[0].daddr));
            end
            if (up_ready) begin
                if (q.size() == 0) begin
                    check("R9", "unexpected ready", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check("R9", {it.tag, " ready cycle"}, 32'(lat_c), 32'(it.lat));
                    check(it.tag, "downstream accesses", 32'(acc_c), 32'(it.acc));
                    check(it.tag, "downstream reads", 32'(rd_c), 32'(it.rdacc));
                    if (!it.we) check(it.tag, "read data", up_rdata, it.rd);
                end
                lat_c = 0;
                acc_c = 0;
                rd_c = 0;
            end
        end
    end

    // Driver: computes the expected result from the requirements and runs one request.
    task automatic access(input logic we, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] wd, input logic [1:0] cls, input string tag);
        item_t it;
        logic [31:0] m;
        int sh;
        int idx;
        logic bad;
        idx = int'(a[5:2]);
        m = (sz == 2'b00) ? 32'hFF : (sz == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
        sh = (sz == 2'b10) ? 0 : int'(a[1:0]) * 8;
        bad = (sz == 2'b11) || (sz == 2'b01 && a[0]);
        it.tag = tag; it.we = we; it.rd = '0; it.lat = 1; it.acc = 0; it.rdacc = 0;
        it.daddr = {a[11:2], 2'b00};
        if (bad) begin
        end else if (!we) begin
            if (cls != 2'b11) begin
                it.lat = 2; it.acc = 1; it.rdacc = 1;
                it.rd = exp_mem[idx] >> sh;
            end
        end else if (cls[1]) begin
        end else if (sz == 2'b10) begin
            it.acc = 1; exp_mem[idx] = wd;
        end else if (cls == 2'b00) begin
            it.lat = 2; it.acc = 2; it.rdacc = 1;
            exp_mem[idx] = (exp_mem[idx] & ~(m << sh)) | ((wd & m) << sh);
        end else begin
            it.acc = 1; exp_mem[idx] = (wd & m) << sh;
        end
        q.push_back(it);
        @(posedge clk); #1;
        up_valid = 1'b1; up_we = we; up_size = sz; up_addr = a; up_wdata = wd; up_class = cls;
        for (int g = 0; g < 10; g++) begin
            @(negedge clk);
            if (up_ready) break;
        end
        @(posedge clk); #1;
        up_valid = 1'b0;
        check(tag, "register file word", mem[idx], exp_mem[idx]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'h1122_3344 + 32'(i) * 32'h0101_0101;
            exp_mem[i] = mem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "ready in reset", 32'(up_ready), 32'd0);
        check("R1", "dn_valid in reset", 32'(dn_valid), 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready idle", 32'(up_ready), 32'd0);
        check("R1", "dn_valid idle", 32'(dn_valid), 32'd0);

        access(1'b0, 2'b10, 12'h004, 32'h0, 2'b00, "R3");
        for (int o = 0; o < 4; o++) access(1'b0, 2'b00, 12'h008 + 12'(o), 32'h0, 2'b00, "R2");
        access(1'b0, 2'b01, 12'h00C, 32'h0, 2'b00, "R2");
        access(1'b0, 2'b01, 12'h00E, 32'h0, 2'b00, "R2");
        access(1'b0, 2'b00, 12'h011, 32'h0, 2'b10, "R2");
        access(1'b0, 2'b10, 12'h014, 32'h0, 2'b11, "R6");
        access(1'b1, 2'b10, 12'h018, 32'hDEAD_BEEF, 2'b00, "R3");
        access(1'b1, 2'b10, 12'h01C, 32'hCAFE_F00D, 2'b01, "R3");
        access(1'b1, 2'b00, 12'h021, 32'hFFFF_FF5A, 2'b00, "R4");
        access(1'b1, 2'b01, 12'h026, 32'hABCD_9876, 2'b00, "R4");
        access(1'b1, 2'b00, 12'h028, 32'h0000_00C3, 2'b00, "R4");
        access(1'b0, 2'b00, 12'h021, 32'h0, 2'b00, "R4");
        access(1'b1, 2'b00, 12'h02F, 32'h1234_5681, 2'b01, "R5");
        access(1'b1, 2'b01, 12'h030, 32'hFFFF_0F0F, 2'b01, "R5");
        access(1'b1, 2'b01, 12'h036, 32'h0000_8001, 2'b01, "R5");
        access(1'b1, 2'b00, 12'h038, 32'h0000_00FF, 2'b10, "R6");
        access(1'b1, 2'b10, 12'h03C, 32'h5555_AAAA, 2'b11, "R6");
        access(1'b1, 2'b01, 12'h009, 32'h0000_7777, 2'b00, "R7");
        access(1'b0, 2'b01, 12'h00B, 32'h0, 2'b00, "R7");
        access(1'b1, 2'b11, 12'h004, 32'h0000_0001, 2'b01, "R7");
        access(1'b0, 2'b11, 12'h004, 32'h0, 2'b00, "R7");
        access(1'b0, 2'b10, 12'h027, 32'h0, 2'b00, "R8");

        repeat (3) @(posedge clk);
        check("R9", "queue drained", 32'(q.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule